// File: doc/BRIEF.md
# Wide Operand Fetch and Assembler

This block fetches one data operand for a processor whose memory is organised in 16-bit locations and hands the operand back at 8, 16 or 32 bits. On a start request it forms the effective address by adding a zero-extended 16-bit offset to one of eight selectable 32-bit index values. It then reads one location for the narrow widths, or two consecutive locations for the 32-bit width, and packs the result into a 32-bit value that is zero-extended when narrow.

A 32-bit operand is assembled in an interleaved order. The low bytes of the two words form the lower half of the result, and the high bytes form the upper half. As a result, a pair of words whose high bytes are zero yields exactly the 16-bit address value that older code stores low byte first. The memory side is a valid/ready request channel with a separate response strobe, and only one read is outstanding at any time. A request stays valid with a stable address until it is accepted. There is no back-pressure on responses: the block always takes a response in the cycle it arrives.

Start is accepted only while `start_ready` is high. Completion is a one-cycle `done` strobe with `operand` (and `illegal`) valid in that cycle.

Top module: `wide_operand_fetch`

## Requirements
- R1: Width code 0 (8-bit) issues exactly one read at the effective address EA, and the operand is the low byte of the word read, zero-extended to 32 bits.
- R2: Width code 1 (16-bit) issues exactly one read at EA, and the operand is the word read, zero-extended to 32 bits.
- R3: Width code 2 (32-bit) issues exactly two reads: the first at EA and the second at EA+1, with 32-bit wraparound.
- R4: For a 32-bit operand with first word W0 and second word W1, the operand is {W1[15:8], W0[15:8], W1[7:0], W0[7:0]}. For example, words 16'hAABB then 16'hCCDD give 32'hCCAADDBB.
- R5: When the upper bytes of both words are zero, the 32-bit operand equals {16'h0, W1[7:0], W0[7:0]}.
- R6: EA = zero-extended `offset` plus the index value picked by `index_sel`, modulo 2^32. Encodings: 0 = status register (reads as zero), 1 = `reg_z`, 2 = `reg_sp`, 3 = `reg_pc`, 4..7 = Y0..Y3, where Yk is `reg_y[32k+31:32k]`.
- R7: Width code 3 is reserved. It issues no read and completes with `done` and `illegal` both high and `operand` equal to zero.
- R8: `done` is a one-cycle pulse. `busy` is high from the cycle after the start is accepted until the cycle before `done`. `start_ready` is low while busy, and a start presented then is ignored.
- R9: Once `mem_req_valid` is raised, it and `mem_req_addr` stay stable until `mem_req_ready` is seen high, and no request is made while idle.
- R10: After reset, `busy`, `done`, `illegal` and `mem_req_valid` are low and `start_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start request; taken when `start_ready` is high |
| start_ready | output | 1 | Block is idle and can take a start |
| offset | input | 16 | Address offset, zero-extended |
| index_sel | input | 3 | Index register selector (see R6) |
| width_code | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| reg_y | input | 128 | Four Y index registers, Y0 in the low 32 bits |
| reg_z | input | 32 | Z register contents |
| reg_sp | input | 32 | Stack pointer contents |
| reg_pc | input | 32 | Program counter contents |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle per request) |
| mem_rsp_data | input | 16 | Read data word |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Reserved width code seen; valid with `done` |
| operand | output | 32 | Packed operand; valid with `done` |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request, never sends a response before its request has been accepted, and never responds while the block is idle. They also assume that the index registers and start fields are sampled only in the accept cycle. The stimulus holds to this through a memory model that keeps at most one read pending, withholds `mem_req_ready` while a read is pending, and adds a random wait of zero to three cycles before each response. The sweep covers every selector, every width code, and offsets at both ends of their range, with and without stalls on the request channel.

// File: rtl/wof_pkg.sv
package wof_pkg;

  // width code values seen on width_code
  localparam logic [1:0] WID_BYTE = 2'd0;
  localparam logic [1:0] WID_HALF = 2'd1;
  localparam logic [1:0] WID_LONG = 2'd2;
  localparam logic [1:0] WID_RSVD = 2'd3;

  // fixed index selector slots ahead of the Y bank
  localparam int SEL_STATUS = 0;
  localparam int SEL_Z      = 1;
  localparam int SEL_SP     = 2;
  localparam int SEL_PC     = 3;
  localparam int SEL_Y_BASE = 4;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_REQ_LO,
    FS_RSP_LO,
    FS_REQ_HI,
    FS_RSP_HI,
    FS_BAD
  } fetch_state_t;

endpackage

// File: rtl/wof_ea_calc.sv
module wof_ea_calc
  import wof_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int NY     = 4,
  localparam int NSEL  = SEL_Y_BASE + NY,
  localparam int SEL_W = $clog2(NSEL)
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic [OFF_W-1:0]     offset,
  input  logic [NY*ADDR_W-1:0] reg_y,
  input  logic [ADDR_W-1:0]    reg_z,
  input  logic [ADDR_W-1:0]    reg_sp,
  input  logic [ADDR_W-1:0]    reg_pc,
  output logic [ADDR_W-1:0]    ea
);

  logic [ADDR_W-1:0] cand [NSEL];

  // the status register never contributes to an address
  assign cand[SEL_STATUS] = '0;
  assign cand[SEL_Z]      = reg_z;
  assign cand[SEL_SP]     = reg_sp;
  assign cand[SEL_PC]     = reg_pc;

  for (genvar g = 0; g < NY; g++) begin : g_ybank
    assign cand[SEL_Y_BASE+g] = reg_y[g*ADDR_W +: ADDR_W];
  end

  assign ea = {{(ADDR_W-OFF_W){1'b0}}, offset} + cand[sel];

endmodule

// File: rtl/wof_pack.sv
module wof_pack
  import wof_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int HB    = WORD_W / 2,
  localparam int OP_W  = 2 * WORD_W
) (
  input  logic [1:0]        wid,
  input  logic [WORD_W-1:0] w_lo,
  input  logic [WORD_W-1:0] w_hi,
  output logic [OP_W-1:0]   packed_op
);

  always_comb begin
    unique case (wid)
      WID_BYTE: packed_op = {{(OP_W-HB){1'b0}}, w_lo[HB-1:0]};
      WID_HALF: packed_op = {{(OP_W-WORD_W){1'b0}}, w_lo};
      // upper bytes of both words on top, lower bytes below
      WID_LONG: packed_op = {w_hi[WORD_W-1:HB], w_lo[WORD_W-1:HB],
                             w_hi[HB-1:0], w_lo[HB-1:0]};
      default:  packed_op = '0;
    endcase
  end

endmodule

// File: rtl/wof_ctrl.sv
module wof_ctrl
  import wof_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  localparam int OP_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] ea_in,
  input  logic [1:0]        wid_in,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [1:0]        wid_q,
  output logic [WORD_W-1:0] pack_lo,
  output logic [WORD_W-1:0] pack_hi,
  input  logic [OP_W-1:0]   packed_op,
  output logic [OP_W-1:0]   operand
);

  fetch_state_t      state;
  logic [ADDR_W-1:0] ea_q;
  logic [WORD_W-1:0] w_lo_q;

  assign start_ready   = (state == FS_IDLE);
  assign busy          = (state != FS_IDLE);
  assign mem_req_valid = (state == FS_REQ_LO) || (state == FS_REQ_HI);
  assign mem_req_addr  = (state == FS_REQ_HI) ? ea_q + ADDR_W'(1) : ea_q;

  // first word comes straight off the bus when it finishes the fetch
  assign pack_lo = (state == FS_RSP_LO) ? mem_rsp_data : w_lo_q;
  assign pack_hi = mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FS_IDLE;
      ea_q    <= '0;
      wid_q   <= WID_BYTE;
      w_lo_q  <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
      operand <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      unique case (state)
        FS_IDLE: begin
          if (start_valid) begin
            ea_q  <= ea_in;
            wid_q <= wid_in;
            state <= (wid_in == WID_RSVD) ? FS_BAD : FS_REQ_LO;
          end
        end
        FS_REQ_LO: begin
          if (mem_req_ready) state <= FS_RSP_LO;
        end
        FS_RSP_LO: begin
          if (mem_rsp_valid) begin
            w_lo_q <= mem_rsp_data;
            if (wid_q == WID_LONG) begin
              state <= FS_REQ_HI;
            end else begin
              operand <= packed_op;
              done    <= 1'b1;
              state   <= FS_IDLE;
            end
          end
        end
        FS_REQ_HI: begin
          if (mem_req_ready) state <= FS_RSP_HI;
        end
        FS_RSP_HI: begin
          if (mem_rsp_valid) begin
            operand <= packed_op;
            done    <= 1'b1;
            state   <= FS_IDLE;
          end
        end
        FS_BAD: begin
          operand <= '0;
          done    <= 1'b1;
          illegal <= 1'b1;
          state   <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wide_operand_fetch.sv
module wide_operand_fetch
  import wof_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int OFF_W  = 16,
  parameter int NY     = 4,
  localparam int SEL_W = $clog2(SEL_Y_BASE + NY),
  localparam int OP_W  = 2 * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_valid,
  output logic                 start_ready,
  input  logic [OFF_W-1:0]     offset,
  input  logic [SEL_W-1:0]     index_sel,
  input  logic [1:0]           width_code,
  input  logic [NY*ADDR_W-1:0] reg_y,
  input  logic [ADDR_W-1:0]    reg_z,
  input  logic [ADDR_W-1:0]    reg_sp,
  input  logic [ADDR_W-1:0]    reg_pc,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data,
  output logic                 busy,
  output logic                 done,
  output logic                 illegal,
  output logic [OP_W-1:0]      operand
);

  logic [ADDR_W-1:0] ea;
  logic [1:0]        wid_q;
  logic [WORD_W-1:0] pack_lo;
  logic [WORD_W-1:0] pack_hi;
  logic [OP_W-1:0]   packed_op;

  wof_ea_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NY(NY)) u_ea (
    .sel(index_sel), .offset(offset), .reg_y(reg_y), .reg_z(reg_z),
    .reg_sp(reg_sp), .reg_pc(reg_pc), .ea(ea)
  );

  wof_pack #(.WORD_W(WORD_W)) u_pack (
    .wid(wid_q), .w_lo(pack_lo), .w_hi(pack_hi), .packed_op(packed_op)
  );

  wof_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .start_ready(start_ready), .ea_in(ea), .wid_in(width_code),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done),
    .illegal(illegal), .wid_q(wid_q), .pack_lo(pack_lo),
    .pack_hi(pack_hi), .packed_op(packed_op), .operand(operand)
  );

endmodule

// File: rtl/wof_checker.sv
module wof_checker #(
  parameter int ADDR_W = 32,
  parameter int OP_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic [1:0]        width_code,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic [OP_W-1:0]   operand
);

  logic [1:0]        seen_wid;
  logic [1:0]        hs_cnt;
  logic [ADDR_W-1:0] first_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wid   <= 2'd0;
      hs_cnt     <= 2'd0;
      first_addr <= '0;
    end else if (start_valid && start_ready) begin
      seen_wid <= width_code;
      hs_cnt   <= 2'd0;
    end else if (mem_req_valid && mem_req_ready) begin
      hs_cnt <= hs_cnt + 2'd1;
      if (hs_cnt == 2'd0) first_addr <= mem_req_addr;
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && start_ready);
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ready);
  p_one_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done && seen_wid == 2'd0 |-> hs_cnt == 2'd1 && operand[OP_W-1:8] == '0);
  p_one_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && seen_wid == 2'd1 |-> hs_cnt == 2'd1 && operand[OP_W-1:16] == '0);
  p_two_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && seen_wid == 2'd2 |-> hs_cnt == 2'd2);
  p_next_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && hs_cnt == 2'd1 |-> mem_req_addr == first_addr + ADDR_W'(1));
  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && seen_wid == 2'd3 |-> illegal && hs_cnt == 2'd0 && operand == '0);

endmodule

bind wide_operand_fetch wof_checker #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
  .start_ready(start_ready), .width_code(width_code),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .busy(busy), .done(done),
  .illegal(illegal), .operand(operand)
);

// File: tb/wide_operand_fetch_test.sv
`timescale 1ns/1ps
module wide_operand_fetch_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_valid = 1'b0;
  logic         start_ready;
  logic [15:0]  offset = '0;
  logic [2:0]   index_sel = '0;
  logic [1:0]   width_code = '0;
  logic [127:0] reg_y;
  logic [31:0]  reg_z, reg_sp, reg_pc;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [15:0]  mem_rsp_data = '0;
  logic         busy, done, illegal;
  logic [31:0]  operand;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  wide_operand_fetch uut (.*);

  // memory model state
  bit          stall_en = 1'b0;
  bit          legacy = 1'b0;
  bit          pend = 1'b0;
  bit          hs_next = 1'b0;
  bit          hold_prev = 1'b0;
  int          pcnt = 0;
  int          req_cnt = 0;
  int          hold_err = 0;
  logic [31:0] paddr, hs_addr, hold_addr;
  logic [31:0] req_log [4];
  logic [7:0]  lfsr = 8'hA5;

  function automatic logic [15:0] memf(logic [31:0] a, bit leg);
    logic [15:0] p;
    p = a[15:0] * 16'h9E37;
    if (leg) return {8'h00, a[7:0] ^ 8'hC3};
    return p ^ a[31:16];
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      pend = 1'b0;
      hs_next = 1'b0;
      hold_prev = 1'b0;
    end else begin
      if (hold_prev && (!mem_req_valid || mem_req_addr != hold_addr))
        hold_err++;
      mem_rsp_valid = 1'b0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (hs_next) begin
        pend = 1'b1;
        paddr = hs_addr;
        pcnt = stall_en ? int'(lfsr[2:1]) : 0;
        if (req_cnt < 4) req_log[req_cnt] = hs_addr;
        req_cnt++;
      end
      if (pend) begin
        if (pcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = memf(paddr, legacy);
          pend = 1'b0;
        end else pcnt--;
      end
      mem_req_ready = !pend && !mem_rsp_valid && (!stall_en || lfsr[0]);
      hs_next = mem_req_valid && mem_req_ready;
      hs_addr = mem_req_addr;
      hold_prev = mem_req_valid && !mem_req_ready;
      hold_addr = mem_req_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] yreg(int k);
    return 32'h0001_0000 * (k + 1) + 32'h0000_0123 * k;
  endfunction

  task automatic run(input logic [15:0] off, input logic [2:0] sel,
                     input logic [1:0] wid, input bit intrude);
    logic [31:0] idx, ea, exp_op;
    logic [15:0] m0, m1;
    int n;
    case (sel)
      3'd0: idx = 32'h0;
      3'd1: idx = reg_z;
      3'd2: idx = reg_sp;
      3'd3: idx = reg_pc;
      default: idx = yreg(int'(sel) - 4);
    endcase
    ea = {16'h0, off} + idx;
    m0 = memf(ea, legacy);
    m1 = memf(ea + 32'd1, legacy);
    case (wid)
      2'd0: exp_op = {24'h0, m0[7:0]};
      2'd1: exp_op = {16'h0, m0};
      2'd2: exp_op = legacy ? {16'h0, m1[7:0], m0[7:0]}
                            : {m1[15:8], m0[15:8], m1[7:0], m0[7:0]};
      default: exp_op = 32'h0;
    endcase
    @(negedge clk);
    offset = off; index_sel = sel; width_code = wid;
    start_valid = 1'b1;
    req_cnt = 0;
    @(negedge clk);
    start_valid = 1'b0;
    if (intrude) begin
      chk("R8 busy after accept", {31'h0, busy}, 32'h1);
      chk("R8 start_ready low while busy", {31'h0, start_ready}, 32'h0);
      start_valid = 1'b1;
      width_code = 2'd3;
      @(negedge clk);
      start_valid = 1'b0;
      width_code = wid;
    end
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R8 done reached", {31'h0, done}, 32'h1);
    chk("R8 not busy at done", {31'h0, busy}, 32'h0);
    if (wid == 2'd3) begin
      chk("R7 illegal flag", {31'h0, illegal}, 32'h1);
      chk("R7 no read", req_cnt, 32'd0);
      chk("R7 zero operand", operand, 32'h0);
    end else begin
      chk("R7 illegal low", {31'h0, illegal}, 32'h0);
      chk("R6 first address", req_log[0], ea);
      if (wid == 2'd2) begin
        chk("R3 two reads", req_cnt, 32'd2);
        chk("R3 second address", req_log[1], ea + 32'd1);
        chk(legacy ? "R5 legacy operand" : "R4 packed operand", operand, exp_op);
      end else begin
        chk(wid == 2'd0 ? "R1 one read" : "R2 one read", req_cnt, 32'd1);
        chk(wid == 2'd0 ? "R1 byte operand" : "R2 half operand", operand, exp_op);
      end
    end
    @(negedge clk);
    chk("R8 done single cycle", {31'h0, done}, 32'h0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) reg_y[k*32 +: 32] = yreg(k);
    reg_z = 32'h8000_0000;
    reg_sp = 32'h0000_01FF;
    reg_pc = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R10 busy at reset", {31'h0, busy}, 32'h0);
    chk("R10 done at reset", {31'h0, done}, 32'h0);
    chk("R10 request at reset", {31'h0, mem_req_valid}, 32'h0);
    chk("R10 illegal at reset", {31'h0, illegal}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 start_ready after reset", {31'h0, start_ready}, 32'h1);
    // sweep of selectors, widths and edge offsets, with and without stalls
    for (int st = 0; st < 2; st++) begin
      stall_en = (st == 1);
      for (int s = 0; s < 8; s++)
        for (int w = 0; w < 4; w++)
          for (int o = 0; o < 4; o++)
            run((o == 0) ? 16'h0000 : (o == 1) ? 16'h0001 :
                (o == 2) ? 16'h7FFF : 16'hFFFF, 3'(s), 2'(w), 1'b0);
    end
    // legacy words: upper bytes all zero
    legacy = 1'b1;
    for (int s = 0; s < 8; s++) run(16'h1234, 3'(s), 2'd2, 1'b0);
    legacy = 1'b0;
    // a start while busy is ignored
    stall_en = 1'b0;
    run(16'h0040, 3'd4, 2'd2, 1'b1);
    run(16'h0041, 3'd2, 2'd0, 1'b1);
    stall_en = 1'b1;
    run(16'h0042, 3'd3, 2'd1, 1'b1);
    chk("R9 request held under back-pressure", hold_err, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule